// File: doc/BRIEF.md
# Processor Test I/O Register Bank

This block sits on the 8-bit I/O port bus of a processor under test and gives test programs a few registers whose accesses have side effects. A checksum register can be loaded directly or fed bytes through a separate add-only port, so a program can compare a hardware sum against one it computed itself. A sequence register hands out an ascending value on every read. A countdown register pulls an active-low interrupt line a programmed number of clocks after it is written. A timeout counter raises a sticky flag once it has counted up to a 16-bit limit.

The bus is a plain synchronous strobe interface. Address and write data are sampled on the rising clock edge while the write strobe is high. Read data is combinational. It is valid in the same cycle as the read strobe and shows the register value from before any read side effect. Reset is asynchronous and active low.

Top module: `io_test_regs`

## Requirements
- R1: A write to address 0x91 loads the 8-bit checksum, and a read of 0x91 returns it.
- R2: Each write to address 0x92 adds the written byte to the checksum, wrapping modulo 256 (0x10 + 0xF5 gives 0x05).
- R3: A read of 0x93 returns the current sequence value, which then increments by one with 8-bit wraparound, so 0xFF is followed by 0x00.
- R4: A write to 0x93 loads the sequence value. When a read and a write of 0x93 fall in the same cycle, the read returns the old value and the written value is kept, with no increment.
- R5: Writing a nonzero N to 0x90 makes irq_n go low at the Nth rising edge after the edge that took the write. A read of 0x90 returns the clocks remaining (0 when idle).
- R6: Once low, irq_n stays low until 0x90 is written again. Any write to 0x90 deasserts irq_n, and writing 0 cancels a pending countdown.
- R7: The timeout limit is 16 bits: 0x84 holds the high byte and 0x83 the low byte, and both read back. In control register 0x82, bit 0 enables counting and reads back. Bit 1 clears the counter and flag, and reads as 0.
- R8: After a control write with clear and enable, timeout_flag rises at the (L+1)th rising edge after the write edge, where L is the limit. The flag stays set until a clear or reset. While counting is disabled, the counter holds.
- R9: A read of 0x92 or of any undecoded address returns 0x00 and changes no register. rdata is 0x00 whenever rd_stb is low.
- R10: Reset clears every register to 0, drives irq_n high and timeout_flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Port address |
| wdata | input | 8 | Write data |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| rdata | output | 8 | Read data, combinational |
| irq_n | output | 1 | Countdown interrupt, active low |
| timeout_flag | output | 1 | Sticky timeout indication |

## Verification
The hardest situation to reach is a read and a write of the sequence port in the same cycle. A processor never issues that, so the stimulus drives both strobes together at address 0x93 and then reads the port again to see which value won. The countdown edge is also checked at an exact clock: the bench counts idle cycles after the write and samples irq_n just before and just after the expected edge. A second timeout run uses a limit with only the high byte set, which shows that the byte order is honoured.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
    localparam int DATA_W = 8;
    localparam int LIMIT_W = 2 * DATA_W;

    localparam logic [7:0] PORT_TO_CTRL = 8'h82;
    localparam logic [7:0] PORT_TO_LO   = 8'h83;
    localparam logic [7:0] PORT_TO_HI   = 8'h84;
    localparam logic [7:0] PORT_CDOWN   = 8'h90;
    localparam logic [7:0] PORT_SUM     = 8'h91;
    localparam logic [7:0] PORT_SUM_ADD = 8'h92;
    localparam logic [7:0] PORT_SEQ     = 8'h93;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;

    typedef struct packed {
        logic sum_ld;
        logic sum_add;
        logic seq_ld;
        logic seq_rd;
        logic cd_ld;
        logic to_ctrl;
        logic to_lo;
        logic to_hi;
    } strobe_t;
endpackage

// File: rtl/tpb_checksum.sv
module tpb_checksum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic         add,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] sum
);
    typedef struct packed {
        logic [W-1:0] sum;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.sum = wdata;
        end else if (add) begin
            st_d.sum = st_q.sum + wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum = st_q.sum;

    // R1
    sum_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> sum == $past(wdata));

    // R2
    sum_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !ld) |=> sum == W'($past(sum) + $past(wdata)));
endmodule

// File: rtl/tpb_seqreg.sv
module tpb_seqreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic         rd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value
);
    typedef struct packed {
        logic [W-1:0] val;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.val = wdata;
        end else if (rd) begin
            st_d.val = st_q.val + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.val;

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !ld) |=> value == W'($past(value) + 1));

    // R4
    seq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> value == $past(wdata));
endmodule

// File: rtl/tpb_countdown.sv
module tpb_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] remain,
    output logic         irq_n
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         fired;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.cnt   = wdata;
            st_d.fired = 1'b0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == W'(1)) begin
                st_d.fired = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign remain = st_q.cnt;
    assign irq_n  = ~st_q.fired;

    // R5
    irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(remain) == W'(1) && !$past(ld)));

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !ld) |=> !irq_n);

    // R6
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> irq_n);
endmodule

// File: rtl/tpb_timeout.sv
module tpb_timeout #(
    parameter int LW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_wr,
    input  logic            lo_wr,
    input  logic            hi_wr,
    input  logic [LW/2-1:0] wdata,
    output logic [LW-1:0]   limit,
    output logic            enabled,
    output logic            flag
);
    import tpb_pkg::*;

    localparam int BW = LW / 2;

    typedef struct packed {
        logic [LW-1:0] lim;
        logic [LW-1:0] cnt;
        logic          en;
        logic          flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lo_wr) st_d.lim[BW-1:0]  = wdata;
        if (hi_wr) st_d.lim[LW-1:BW] = wdata;
        if (ctrl_wr) begin
            st_d.en = wdata[CTRL_EN_BIT];
            if (wdata[CTRL_CLR_BIT]) begin
                st_d.cnt  = '0;
                st_d.flag = 1'b0;
            end
        end else if (st_q.en && !st_q.flag) begin
            if (st_q.cnt == st_q.lim) begin
                st_d.flag = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign limit   = st_q.lim;
    assign enabled = st_q.en;
    assign flag    = st_q.flag;

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(ctrl_wr && wdata[CTRL_CLR_BIT])) |=> flag);

    // R8
    flag_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(enabled));

    // R7
    clr_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata[CTRL_CLR_BIT]) |=> !flag);
endmodule

// File: rtl/io_test_regs.sv
module io_test_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       rd_stb,
    input  logic       wr_stb,
    output logic [7:0] rdata,
    output logic       irq_n,
    output logic       timeout_flag
);
    import tpb_pkg::*;

    strobe_t              stb;
    logic [DATA_W-1:0]    sum_val;
    logic [DATA_W-1:0]    seq_val;
    logic [DATA_W-1:0]    cd_remain;
    logic [LIMIT_W-1:0]   to_limit;
    logic                 to_en;

    always_comb begin
        stb         = '0;
        stb.sum_ld  = wr_stb && (addr == PORT_SUM);
        stb.sum_add = wr_stb && (addr == PORT_SUM_ADD);
        stb.seq_ld  = wr_stb && (addr == PORT_SEQ);
        stb.seq_rd  = rd_stb && (addr == PORT_SEQ);
        stb.cd_ld   = wr_stb && (addr == PORT_CDOWN);
        stb.to_ctrl = wr_stb && (addr == PORT_TO_CTRL);
        stb.to_lo   = wr_stb && (addr == PORT_TO_LO);
        stb.to_hi   = wr_stb && (addr == PORT_TO_HI);
    end

    tpb_checksum #(.W(DATA_W)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (stb.sum_ld),
        .add   (stb.sum_add),
        .wdata (wdata),
        .sum   (sum_val)
    );

    tpb_seqreg #(.W(DATA_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (stb.seq_ld),
        .rd    (stb.seq_rd),
        .wdata (wdata),
        .value (seq_val)
    );

    tpb_countdown #(.W(DATA_W)) u_cd (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (stb.cd_ld),
        .wdata  (wdata),
        .remain (cd_remain),
        .irq_n  (irq_n)
    );

    tpb_timeout #(.LW(LIMIT_W)) u_to (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (stb.to_ctrl),
        .lo_wr   (stb.to_lo),
        .hi_wr   (stb.to_hi),
        .wdata   (wdata),
        .limit   (to_limit),
        .enabled (to_en),
        .flag    (timeout_flag)
    );

    always_comb begin
        rdata = '0;
        if (rd_stb) begin
            case (addr)
                PORT_SUM:     rdata = sum_val;
                PORT_SEQ:     rdata = seq_val;
                PORT_CDOWN:   rdata = cd_remain;
                PORT_TO_LO:   rdata = to_limit[DATA_W-1:0];
                PORT_TO_HI:   rdata = to_limit[LIMIT_W-1:DATA_W];
                PORT_TO_CTRL: rdata = {{(DATA_W-1){1'b0}}, to_en};
                default:      rdata = '0;
            endcase
        end
    end

    // R9
    quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && addr != PORT_SEQ) |=> ($stable(seq_val) && $stable(sum_val)));

    // R9
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |-> rdata == '0);
endmodule

// File: tb/io_test_regs_test.sv
`timescale 1ns/1ps
module io_test_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] rdata;
    logic       irq_n;
    logic       timeout_flag;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    io_test_regs uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .wdata        (wdata),
        .rd_stb       (rd_stb),
        .wr_stb       (wr_stb),
        .rdata        (rdata),
        .irq_n        (irq_n),
        .timeout_flag (timeout_flag)
    );

    // behavioural reference model
    int m_sum, m_seq, m_cd, m_fired, m_lim, m_en, m_tcnt, m_tflag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sum = 0; m_seq = 0; m_cd = 0; m_fired = 0;
            m_lim = 0; m_en = 0; m_tcnt = 0; m_tflag = 0;
        end else begin
            bit ctrl_w;
            ctrl_w = wr_stb && addr == 8'h82;
            if (wr_stb && addr == 8'h91) m_sum = wdata;
            if (wr_stb && addr == 8'h92) m_sum = (m_sum + wdata) % 256;
            if (wr_stb && addr == 8'h93) m_seq = wdata;
            else if (rd_stb && addr == 8'h93) m_seq = (m_seq + 1) % 256;
            if (wr_stb && addr == 8'h90) begin
                m_cd = wdata; m_fired = 0;
            end else if (m_cd > 0) begin
                if (m_cd == 1) m_fired = 1;
                m_cd = m_cd - 1;
            end
            if (wr_stb && addr == 8'h83) m_lim = (m_lim / 256) * 256 + wdata;
            if (wr_stb && addr == 8'h84) m_lim = (m_lim % 256) + wdata * 256;
            if (ctrl_w) begin
                m_en = wdata[0];
                if (wdata[1]) begin m_tcnt = 0; m_tflag = 0; end
            end else if (m_en != 0 && m_tflag == 0) begin
                if (m_tcnt == m_lim) m_tflag = 1;
                else m_tcnt = m_tcnt + 1;
            end
        end
    end

    function automatic int model_rdata();
        if (!rd_stb) return 0;
        case (addr)
            8'h91: return m_sum;
            8'h93: return m_seq;
            8'h90: return m_cd;
            8'h83: return m_lim % 256;
            8'h84: return m_lim / 256;
            8'h82: return m_en;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h91: return "R1";
            8'h93: return "R3";
            8'h90: return "R5";
            8'h82, 8'h83, 8'h84: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(int'(rdata), model_rdata(), tag_of(addr), "rdata vs model");
            check(int'(irq_n), m_fired ? 0 : 1, "R5", "irq_n vs model");
            check(int'(timeout_flag), m_tflag, "R8", "flag vs model");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic op(input logic [7:0] a, input logic r, input logic w, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; rd_stb = r; wr_stb = w; wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(8'h00, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        op(a, 1'b0, 1'b1, d);
    endtask

    task automatic rd_chk(input logic [7:0] a, input int exp, input string tag);
        op(a, 1'b1, 1'b0, 8'h00);
        @(negedge clk);
        check(int'(rdata), exp, tag, "read");
    endtask

    initial begin
        idle(3);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(int'(irq_n), 1, "R10", "irq_n after reset");
        check(int'(timeout_flag), 0, "R10", "flag after reset");
        rd_chk(8'h91, 8'h00, "R10");
        rd_chk(8'h93, 8'h00, "R10");

        // R1 load and read back
        wr(8'h91, 8'h10);
        rd_chk(8'h91, 8'h10, "R1");
        // R2 accumulate with wrap
        wr(8'h92, 8'hF5);
        rd_chk(8'h91, 8'h05, "R2");
        wr(8'h92, 8'h20);
        rd_chk(8'h91, 8'h25, "R2");

        // R9 write-only and undecoded reads
        rd_chk(8'h92, 8'h00, "R9");
        rd_chk(8'h55, 8'h00, "R9");
        rd_chk(8'h91, 8'h25, "R9");

        // R3 ascending reads with wrap
        wr(8'h93, 8'hFE);
        rd_chk(8'h93, 8'hFE, "R3");
        rd_chk(8'h93, 8'hFF, "R3");
        rd_chk(8'h93, 8'h00, "R3");
        // R4 simultaneous read and write: write wins
        op(8'h93, 1'b1, 1'b1, 8'h40);
        @(negedge clk);
        check(int'(rdata), 8'h01, "R4", "read during load");
        rd_chk(8'h93, 8'h40, "R4");
        rd_chk(8'h94, 8'h00, "R9");
        rd_chk(8'h93, 8'h41, "R9");

        // R5 countdown timing
        wr(8'h90, 8'd5);
        idle(5);
        @(negedge clk);
        check(int'(irq_n), 1, "R5", "irq_n one clock before expiry");
        idle(1);
        @(negedge clk);
        check(int'(irq_n), 0, "R5", "irq_n at expiry");
        // R6 hold, then release by write
        idle(10);
        @(negedge clk);
        check(int'(irq_n), 0, "R6", "irq_n held low");
        wr(8'h90, 8'd0);
        idle(1);
        @(negedge clk);
        check(int'(irq_n), 1, "R6", "irq_n released by write");
        wr(8'h90, 8'd3);
        rd_chk(8'h90, 8'd3, "R5");
        wr(8'h90, 8'd0);
        idle(10);
        @(negedge clk);
        check(int'(irq_n), 1, "R6", "cancelled countdown stays quiet");

        // R7 limit and control readback
        wr(8'h83, 8'd20);
        wr(8'h84, 8'h00);
        rd_chk(8'h83, 8'd20, "R7");
        rd_chk(8'h84, 8'h00, "R7");
        // R8 flag at (L+1)th edge after control write
        wr(8'h82, 8'h03);
        idle(21);
        @(negedge clk);
        check(int'(timeout_flag), 0, "R8", "flag one clock early");
        idle(1);
        @(negedge clk);
        check(int'(timeout_flag), 1, "R8", "flag at limit");
        rd_chk(8'h82, 8'h01, "R7");
        idle(20);
        @(negedge clk);
        check(int'(timeout_flag), 1, "R8", "flag sticky");
        wr(8'h82, 8'h02);
        rd_chk(8'h82, 8'h00, "R7");
        idle(40);
        @(negedge clk);
        check(int'(timeout_flag), 0, "R8", "disabled counter holds");

        // R7 high byte ordering: limit 0x0100
        wr(8'h84, 8'h01);
        wr(8'h83, 8'h00);
        wr(8'h82, 8'h03);
        idle(250);
        @(negedge clk);
        check(int'(timeout_flag), 0, "R7", "high-byte limit not yet reached");
        idle(10);
        @(negedge clk);
        check(int'(timeout_flag), 1, "R7", "high-byte limit reached");

        // R10 reset mid-run
        wr(8'h90, 8'd2);
        idle(5);
        @(posedge clk); #1; rst_n = 1'b0;
        addr = '0; rd_stb = 1'b0; wr_stb = 1'b0;
        @(negedge clk);
        check(int'(irq_n), 1, "R10", "irq_n in reset");
        check(int'(timeout_flag), 0, "R10", "flag in reset");
        @(posedge clk); #1; rst_n = 1'b1;
        rd_chk(8'h91, 8'h00, "R10");
        rd_chk(8'h93, 8'h00, "R10");
        rd_chk(8'h84, 8'h00, "R10");
        rd_chk(8'h82, 8'h00, "R10");
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule